// File: doc/BRIEF.md
# Self-Timed Page Write Controller

This block sits behind a two-wire serial slave front end and turns a write transfer into a timed commit to a 128 x 8 storage array. The front end hands it a word address, then a run of data bytes, each marked by a one-cycle strobe. The block holds those bytes in a four-slot page buffer. Nothing reaches the array until the front end reports a stop condition.

On a stop with at least one buffered byte and the write-control pin low, the block raises `busy` and runs a programming delay of `WR_CYCLES` clocks. It then writes each valid slot to the array, one byte per clock. While `busy` is high the front end must stay deaf to the bus, and the block itself drops every strobe it receives.

When the write-control pin is high at the stop, the buffered page is thrown away. In that case the array stays untouched and no busy period starts.

Top module: `page_commit_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy` and `mem_we` are low.
- R2: Only the low 7 bits of the word address select the location. Bit 7 of the address byte has no effect on where data lands.
- R3: Data bytes fill consecutive locations starting at the word address. The low two address bits wrap within the aligned four-byte page, the upper five bits stay fixed, and a later byte overwrites an earlier one in the same slot.
- R4: No array write happens while data bytes arrive. A commit starts only on a `stop_seen` pulse that finds at least one buffered byte with `wr_lock` low.
- R5: `busy` rises in the cycle after the accepted stop and stays high for exactly `WR_CYCLES + 4` cycles.
- R6: Array writes happen only while `busy` is high, in its last four cycles. There is one write per buffered slot, issued in slot order 0 to 3.
- R7: While `busy` is high, `addr_valid`, `data_valid` and `stop_seen` are ignored. They neither change the array nor start a further cycle.
- R8: A stop with no buffered data byte (an address-only transfer) writes nothing and leaves `busy` low.
- R9: A stop seen with `wr_lock` high discards the buffered bytes. The array is not written and `busy` stays low. Data bytes are still accepted while `wr_lock` is high.
- R10: After a commit, or after a discard, the buffer is empty. A following stop with no new data writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | One-cycle strobe: word address byte received |
| addr_byte | input | 8 | Word address byte; bit 7 ignored |
| data_valid | input | 1 | One-cycle strobe: data byte received |
| data_byte | input | 8 | Data byte |
| stop_seen | input | 1 | One-cycle pulse: stop condition received |
| wr_lock | input | 1 | Write-control pin; high disables writes |
| busy | output | 1 | Internal write cycle running; front end ignores the bus |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 7 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench builds the block with `PAGE_BYTES = 4` and `WR_CYCLES = 20`. A 20-cycle programming delay stands in for the multi-millisecond default, so a full busy period can be counted to the exact cycle. It also leaves room to push address, data and stop strobes into the middle of that period. The four-byte page lets a six-byte transfer that starts at slot 2 show both the wrap and the overwrite. It also lets a two-byte transfer that starts at slot 3 show the slot-order drain.

// File: rtl/page_wr_pkg.sv
package page_wr_pkg;

    localparam int MEM_AW = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_DRAIN = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic              we;
        logic [MEM_AW-1:0] addr;
        logic [BYTE_W-1:0] data;
    } mem_wr_t;

    function automatic logic [MEM_AW-1:0] word_loc(input logic [BYTE_W-1:0] b);
        return b[MEM_AW-1:0];
    endfunction

endpackage

// File: rtl/page_buffer.sv
module page_buffer import page_wr_pkg::*; #(
    parameter int PAGE_BYTES = 4,
    parameter int SLOT_W     = 2,
    parameter int BASE_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_en,
    input  logic              clear,
    input  logic              addr_valid,
    input  logic [MEM_AW-1:0] addr_loc,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [BASE_W-1:0] base,
    output logic [PAGE_BYTES-1:0] valid_mask,
    output logic [BYTE_W-1:0] rd_data
);

    logic [SLOT_W-1:0] wr_ptr;
    logic [BYTE_W-1:0] slot_data [PAGE_BYTES];

    logic take_addr;
    logic take_data;

    assign take_addr = accept_en && addr_valid;
    assign take_data = accept_en && !addr_valid && data_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            base   <= '0;
            wr_ptr <= '0;
        end else if (take_addr) begin
            base   <= addr_loc[MEM_AW-1:SLOT_W];
            wr_ptr <= addr_loc[SLOT_W-1:0];
        end else if (take_data) begin
            wr_ptr <= SLOT_W'(wr_ptr + 1'b1);
        end
    end

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic              v_q;
        logic [BYTE_W-1:0] d_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                d_q <= '0;
            end else if (clear || take_addr) begin
                v_q <= 1'b0;
            end else if (take_data && wr_ptr == SLOT_W'(g)) begin
                v_q <= 1'b1;
                d_q <= data_byte;
            end
        end

        assign valid_mask[g] = v_q;
        assign slot_data[g]  = d_q;
    end

    assign rd_data = slot_data[rd_slot];

endmodule

// File: rtl/cycle_timer.sv
module cycle_timer #(
    parameter int CYCLES = 500000,
    parameter int CNT_W  = 19
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic dec,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(CYCLES - 1);
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/commit_fsm.sv
module commit_fsm import page_wr_pkg::*; #(
    parameter int PAGE_BYTES = 4,
    parameter int SLOT_W     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stop_seen,
    input  logic              wr_lock,
    input  logic              any_valid,
    input  logic              tmr_expired,
    output wr_state_e         state,
    output logic              tmr_load,
    output logic              tmr_dec,
    output logic              buf_clear,
    output logic [SLOT_W-1:0] drain_slot
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(PAGE_BYTES - 1);

    wr_state_e state_q, state_d;
    logic [SLOT_W-1:0] slot_q;

    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_dec   = 1'b0;
        buf_clear = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (stop_seen) begin
                    if (wr_lock) begin
                        buf_clear = 1'b1;
                    end else if (any_valid) begin
                        state_d  = ST_PROG;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_PROG: begin
                if (tmr_expired) state_d = ST_DRAIN;
                else             tmr_dec = 1'b1;
            end
            ST_DRAIN: begin
                if (slot_q == LAST_SLOT) begin
                    state_d   = ST_IDLE;
                    buf_clear = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_DRAIN && slot_q != LAST_SLOT) slot_q <= SLOT_W'(slot_q + 1'b1);
            else                                            slot_q <= '0;
        end
    end

    assign state      = state_q;
    assign drain_slot = slot_q;

endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl import page_wr_pkg::*; #(
    parameter int PAGE_BYTES = 4,
    parameter int WR_CYCLES  = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    input  logic              stop_seen,
    input  logic              wr_lock,
    output logic              busy,
    output logic              mem_we,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata
);

    localparam int SLOT_W = $clog2(PAGE_BYTES);
    localparam int BASE_W = MEM_AW - SLOT_W;
    localparam int CNT_W  = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;

    wr_state_e         state;
    logic              tmr_load, tmr_dec, tmr_expired;
    logic              buf_clear;
    logic [SLOT_W-1:0] drain_slot;
    logic [BASE_W-1:0] page_base;
    logic [PAGE_BYTES-1:0] valid_mask;
    logic [BYTE_W-1:0] slot_byte;
    mem_wr_t           wr;

    assign busy = (state != ST_IDLE);

    page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .SLOT_W     (SLOT_W),
        .BASE_W     (BASE_W)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .accept_en  (!busy),
        .clear      (buf_clear),
        .addr_valid (addr_valid),
        .addr_loc   (word_loc(addr_byte)),
        .data_valid (data_valid),
        .data_byte  (data_byte),
        .rd_slot    (drain_slot),
        .base       (page_base),
        .valid_mask (valid_mask),
        .rd_data    (slot_byte)
    );

    cycle_timer #(
        .CYCLES  (WR_CYCLES),
        .CNT_W   (CNT_W)
    ) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .dec     (tmr_dec),
        .expired (tmr_expired)
    );

    commit_fsm #(
        .PAGE_BYTES  (PAGE_BYTES),
        .SLOT_W      (SLOT_W)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .stop_seen   (stop_seen),
        .wr_lock     (wr_lock),
        .any_valid   (|valid_mask),
        .tmr_expired (tmr_expired),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_dec     (tmr_dec),
        .buf_clear   (buf_clear),
        .drain_slot  (drain_slot)
    );

    always_comb begin
        wr.we   = (state == ST_DRAIN) && valid_mask[drain_slot];
        wr.addr = {page_base, drain_slot};
        wr.data = slot_byte;
    end

    assign mem_we    = wr.we;
    assign mem_addr  = wr.addr;
    assign mem_wdata = wr.data;

endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk import page_wr_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              stop_seen,
    input logic              wr_lock,
    input logic              busy,
    input logic              mem_we,
    input logic [MEM_AW-1:0] mem_addr
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !mem_we));

    p_start_on_stop_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(stop_seen) && !$past(wr_lock)));

    p_we_inside_busy_r6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);

    p_drain_order_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_we && $past(mem_we)) |->
            ((mem_addr[MEM_AW-1:2] == $past(mem_addr[MEM_AW-1:2])) &&
             (mem_addr[1:0] > $past(mem_addr[1:0]))));

    p_lock_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && stop_seen && wr_lock) |=> !busy);

endmodule

bind page_commit_ctrl page_commit_chk u_chk (.*);

// File: tb/page_commit_ctrl_bench.sv
module page_commit_ctrl_bench;

    localparam int WRC = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_valid = 1'b0;
    logic [7:0] addr_byte = '0;
    logic       data_valid = 1'b0;
    logic [7:0] data_byte = '0;
    logic       stop_seen = 1'b0;
    logic       wr_lock = 1'b0;
    logic       busy;
    logic       mem_we;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;

    int total = 0;
    int bad = 0;
    int wr_count = 0;
    int busy_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] shadow [128];
    logic [6:0] wlog [8];

    always #5 clk = ~clk;

    page_commit_ctrl #(.PAGE_BYTES(4), .WR_CYCLES(WRC)) u_page_commit_ctrl (
        .clk(clk), .rst(rst),
        .addr_valid(addr_valid), .addr_byte(addr_byte),
        .data_valid(data_valid), .data_byte(data_byte),
        .stop_seen(stop_seen), .wr_lock(wr_lock),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                shadow[mem_addr] = mem_wdata;
                if (wr_count < 8) wlog[wr_count] = mem_addr;
                wr_count++;
            end
            if (busy) busy_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_addr(input logic [7:0] a);
        @(negedge clk); addr_valid = 1'b1; addr_byte = a;
        @(negedge clk); addr_valid = 1'b0;
    endtask

    task automatic send_data(input logic [7:0] d);
        @(negedge clk); data_valid = 1'b1; data_byte = d;
        @(negedge clk); data_valid = 1'b0;
    endtask

    task automatic send_stop();
        @(negedge clk); stop_seen = 1'b1;
        @(negedge clk); stop_seen = 1'b0;
    endtask

    task automatic settle();
        repeat (WRC + 10) @(negedge clk);
    endtask

    task automatic clear_log();
        wr_count = 0;
        busy_cnt = 0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(!busy && !mem_we, "R1 reset quiet", {busy, mem_we}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !mem_we, "R1 after reset", {busy, mem_we}, 0);
    endtask

    task automatic t_byte_write();
        clear_log();
        send_addr(8'h85);
        send_data(8'hA5);
        repeat (5) @(negedge clk);
        chk(wr_count == 0, "R4 no write before stop", wr_count, 0);
        send_stop();
        settle();
        chk(wr_count == 1, "R2 one byte written", wr_count, 1);
        chk(shadow[7'h05] == 8'hA5, "R2 msb ignored", shadow[7'h05], 8'hA5);
        chk(busy_cnt == WRC + 4, "R5 busy length", busy_cnt, WRC + 4);
    endtask

    task automatic t_page_write();
        clear_log();
        send_addr(8'h10);
        send_data(8'h11); send_data(8'h22); send_data(8'h33); send_data(8'h44);
        send_stop();
        settle();
        chk(wr_count == 4, "R6 four writes", wr_count, 4);
        for (int i = 0; i < 4; i++) begin
            chk(shadow[7'h10 + i] == 8'(8'h11 * (i + 1)), "R3 page data",
                shadow[7'h10 + i], 8'h11 * (i + 1));
            chk(wlog[i] == 7'(7'h10 + i), "R6 slot order", wlog[i], 7'h10 + i);
        end
        chk(busy_cnt == WRC + 4, "R5 busy length page", busy_cnt, WRC + 4);
    endtask

    task automatic t_wrap();
        clear_log();
        send_addr(8'h2E);
        for (int i = 1; i <= 6; i++) send_data(8'(i));
        send_stop();
        settle();
        chk(wr_count == 4, "R3 wrap write count", wr_count, 4);
        chk(shadow[7'h2C] == 8'd3, "R3 wrap slot0", shadow[7'h2C], 3);
        chk(shadow[7'h2D] == 8'd4, "R3 wrap slot1", shadow[7'h2D], 4);
        chk(shadow[7'h2E] == 8'd5, "R3 overwrite slot2", shadow[7'h2E], 5);
        chk(shadow[7'h2F] == 8'd6, "R3 overwrite slot3", shadow[7'h2F], 6);
        chk(shadow[7'h30] == 8'd0, "R3 next page untouched", shadow[7'h30], 0);
        // partial page starting at slot 3: drain goes slot 0 then slot 3
        clear_log();
        send_addr(8'h23);
        send_data(8'hAB); send_data(8'hCD);
        send_stop();
        settle();
        chk(wr_count == 2, "R6 partial count", wr_count, 2);
        chk(wlog[0] == 7'h20 && wlog[1] == 7'h23, "R6 partial order", {wlog[0], wlog[1]}, 14'h1023);
        chk(shadow[7'h23] == 8'hAB && shadow[7'h20] == 8'hCD, "R3 partial data",
            {shadow[7'h23], shadow[7'h20]}, 16'hABCD);
    endtask

    task automatic t_empty();
        clear_log();
        send_addr(8'h40);
        send_stop();
        settle();
        chk(busy_cnt == 0, "R8 no busy", busy_cnt, 0);
        chk(wr_count == 0, "R8 no write", wr_count, 0);
    endtask

    task automatic t_lock();
        clear_log();
        wr_lock = 1'b1;
        send_addr(8'h50);
        send_data(8'h77);
        send_stop();
        settle();
        chk(busy_cnt == 0, "R9 locked no busy", busy_cnt, 0);
        chk(wr_count == 0 && shadow[7'h50] == 8'h00, "R9 locked no write", wr_count, 0);
        wr_lock = 1'b0;
        send_stop();
        settle();
        chk(wr_count == 0 && busy_cnt == 0, "R10 discarded buffer", wr_count + busy_cnt, 0);
    endtask

    task automatic t_busy_ignore();
        clear_log();
        send_addr(8'h60);
        send_data(8'h99);
        send_stop();
        repeat (3) @(negedge clk);
        send_addr(8'h70);
        send_data(8'hEE);
        send_stop();
        settle();
        chk(wr_count == 1, "R7 single commit", wr_count, 1);
        chk(shadow[7'h60] == 8'h99, "R7 first data kept", shadow[7'h60], 8'h99);
        chk(shadow[7'h70] == 8'h00, "R7 busy data dropped", shadow[7'h70], 0);
        chk(busy_cnt == WRC + 4, "R7 no second cycle", busy_cnt, WRC + 4);
        clear_log();
        send_stop();
        settle();
        chk(wr_count == 0 && busy_cnt == 0, "R10 empty after commit", wr_count + busy_cnt, 0);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) shadow[i] = 8'h00;
        for (int i = 0; i < 8; i++) wlog[i] = '0;
        t_reset();
        t_byte_write();
        t_page_write();
        t_wrap();
        t_empty();
        t_lock();
        t_busy_ignore();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule